// File: doc/BRIEF.md
# LPC DMA Peripheral Cycle Engine

This block sits on the peripheral side of a Low Pin Count bus and serves DMA cycles only. It watches the frame strobe and the four-bit multiplexed bus for a start nibble, then decodes a cycle-type nibble that picks the direction. A one-clock nibble follows with the granted channel and the terminal-count flag, then a size nibble. There is no address phase. Bytes cross the bus as two nibbles, high half first. The block drives the bus through an output enable, stays off it while the host turns the bus around, and performs its own turn-around by driving ones for one clock and then releasing.

A simple local byte interface connects the engine to the device behind it. While the block sits in a SYNC window it raises a request and waits for acknowledge. It emits short-wait codes, and long-wait codes once the short budget is spent. On acknowledge it answers with ready-more when further bytes follow, or with ready when the byte is the final one. A fault from the local side is answered with the error code instead. The frame strobe going low at any point abandons the cycle.

Top module: `lpcdma_periph`

## Requirements
- R1: After reset the bus output enable and the local request are both low.
- R2: A cycle starts on a clock with `lframe_n` low and `lad_i` = 0000. On the next clock, `lad_i[3:1]` = 100 selects host-to-device (`dir_o` = 0) and 101 selects device-to-host (`dir_o` = 1). Any other cycle type is ignored: the block never drives the bus and never raises `req_o` for it.
- R3: The clock after the type nibble is the channel nibble. From the following clock onward, `chan_o` equals its bits [2:0] and `tc_o` equals its bit 3.
- R4: The size nibble follows the channel nibble. Its bits [1:0] give the number of bytes: 00 is one byte, 01 is two bytes, 11 is four bytes. The code 10, or any nonzero value in bits [3:2], abandons the cycle without driving the bus.
- R5: For host-to-device cycles, each byte arrives high nibble first, then low nibble, then a two-clock host turn-around. `wdata_o` holds that byte during the SYNC window that follows.
- R6: The output enable stays low during host turn-around clocks. The block's own turn-around drives 1111 for one clock with the enable high, and the enable is low on the next clock.
- R7: In SYNC, while neither `ack_i` nor `fault_i` is high, the block drives 0101 on the first SHORT_WAITS wait clocks and 0110 on every wait clock after that.
- R8: On `ack_i` in SYNC, the block drives 1001 if `tc_o` is low and the byte is not the last one of the size. Otherwise it drives 0000, and the cycle ends after the following data or turn-around.
- R9: `fault_i` in SYNC drives 1010 even when `ack_i` is also high. The block then turns the bus around and returns to idle, with no data phase and no further bytes.
- R10: For device-to-host cycles, the host turn-around comes right after the size nibble. Each accepted SYNC is followed by two driven nibbles: the high and then the low half of the `rdata_i` value presented with `ack_i`. After the last byte comes the block's turn-around.
- R11: `lframe_n` low in any non-idle state abandons the cycle, and the output enable is low on the next clock. If that clock also carries the start nibble, it begins a new cycle.
- R12: `req_o` is high exactly on SYNC clocks, and the bus is driven on every such clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| lframe_n | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | Bus nibble as seen on the pins |
| lad_o | output | 4 | Nibble driven by the block |
| lad_oe | output | 1 | Drive enable for `lad_o` |
| req_o | output | 1 | Local transfer request (SYNC window) |
| dir_o | output | 1 | 0 host-to-device, 1 device-to-host |
| chan_o | output | 3 | Granted DMA channel |
| tc_o | output | 1 | Terminal-count flag of the current cycle |
| wdata_o | output | 8 | Byte received from the host |
| rdata_i | input | 8 | Byte to send to the host, taken with `ack_i` |
| ack_i | input | 1 | Local side completes the current byte |
| fault_i | input | 1 | Local side reports a fault |

## Verification
Two decisions can fall on the same SYNC clock. One is the fault answer against the acknowledge answer. The other is the terminal-count override against the ready-more choice on a byte that is not the last. The sweep raises `fault_i` together with `ack_i` on the final byte. It also crosses `tc_o` high with every multi-byte size. Each SYNC answer is judged against a code the bench derives from the byte index, the byte count and the flags. Frame aborts are also placed inside a wait window, inside a data nibble and on a turn-around clock. In each case the bench checks that the bus is released on the next clock.

// File: rtl/lpcdma_pkg.sv
package lpcdma_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int CHAN_W = 3;
  localparam int IDX_W  = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_CHAN, ST_SIZE,
    ST_DIN_HI, ST_DIN_LO, ST_HTAR1, ST_HTAR2,
    ST_SYNC, ST_DOUT_HI, ST_DOUT_LO, ST_PTAR1, ST_PTAR2
  } dma_st_e;

  localparam logic [NIB_W-1:0] NIB_START  = 4'h0;
  localparam logic [NIB_W-1:0] NIB_ONES   = 4'hF;
  localparam logic [NIB_W-1:0] SYNC_READY = 4'h0;
  localparam logic [NIB_W-1:0] SYNC_SHORT = 4'h5;
  localparam logic [NIB_W-1:0] SYNC_LONG  = 4'h6;
  localparam logic [NIB_W-1:0] SYNC_MORE  = 4'h9;
  localparam logic [NIB_W-1:0] SYNC_ERR   = 4'hA;

  localparam logic [2:0] CT_TO_DEV  = 3'b100;
  localparam logic [2:0] CT_TO_HOST = 3'b101;

  // size nibble acceptable: upper bits clear and a defined byte count
  function automatic logic size_ok(input logic [NIB_W-1:0] n);
    return (n[3:2] == 2'b00) && (n[1:0] != 2'b10);
  endfunction

  // index of the final byte for a size code
  function automatic logic [IDX_W-1:0] size_last_idx(input logic [1:0] c);
    case (c)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  // wait nibble for the cnt-th wait clock of a SYNC window
  function automatic logic [NIB_W-1:0] wait_code(input int unsigned cnt,
                                                 input int unsigned lim);
    return (cnt < lim) ? SYNC_SHORT : SYNC_LONG;
  endfunction

  // completion nibble on acknowledge
  function automatic logic [NIB_W-1:0] done_code(input logic final_byte);
    return final_byte ? SYNC_READY : SYNC_MORE;
  endfunction

endpackage

// File: rtl/lpcdma_fsm.sv
module lpcdma_fsm
  import lpcdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lframe_n,
  input  logic [NIB_W-1:0] lad_i,
  input  logic             sync_done,
  input  logic             sync_err,
  input  logic             sync_more,
  output dma_st_e          st,
  output logic             dir,
  output logic             lad_oe,
  output logic             ev_abort
);

  dma_st_e st_q, st_d;
  logic    dir_q;
  logic    more_q;
  logic    ct_valid;

  assign ct_valid = (lad_i[3:1] == CT_TO_DEV) || (lad_i[3:1] == CT_TO_HOST);
  assign ev_abort = !lframe_n && (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    st_d = ST_IDLE;
      ST_CTYPE:   st_d = ct_valid ? ST_CHAN : ST_IDLE;
      ST_CHAN:    st_d = ST_SIZE;
      ST_SIZE:    st_d = size_ok(lad_i) ? (dir_q ? ST_HTAR1 : ST_DIN_HI) : ST_IDLE;
      ST_DIN_HI:  st_d = ST_DIN_LO;
      ST_DIN_LO:  st_d = ST_HTAR1;
      ST_HTAR1:   st_d = ST_HTAR2;
      ST_HTAR2:   st_d = ST_SYNC;
      ST_SYNC: begin
        if (sync_err)       st_d = ST_PTAR1;
        else if (sync_done) st_d = dir_q ? ST_DOUT_HI : ST_PTAR1;
      end
      ST_DOUT_HI: st_d = ST_DOUT_LO;
      ST_DOUT_LO: st_d = more_q ? ST_SYNC : ST_PTAR1;
      ST_PTAR1:   st_d = ST_PTAR2;
      ST_PTAR2:   st_d = (more_q && !dir_q) ? ST_DIN_HI : ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
    // a low frame strobe overrides every state, start nibble restarts
    if (!lframe_n)
      st_d = (lad_i == NIB_START) ? ST_CTYPE : ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b0;
      more_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_CTYPE)
        dir_q <= lad_i[1];
      if (st_q == ST_SIZE)
        more_q <= 1'b0;
      else if (sync_done || sync_err)
        more_q <= sync_more;
    end
  end

  assign st     = st_q;
  assign dir    = dir_q;
  assign lad_oe = (st_q == ST_SYNC) || (st_q == ST_DOUT_HI) ||
                  (st_q == ST_DOUT_LO) || (st_q == ST_PTAR1);

endmodule

// File: rtl/lpcdma_sync.sv
module lpcdma_sync
  import lpcdma_pkg::*;
#(
  parameter int SHORT_WAITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sync,
  input  logic             lframe_n,
  input  logic             ack_i,
  input  logic             fault_i,
  input  logic             final_byte,
  output logic [NIB_W-1:0] code,
  output logic             done,
  output logic             err,
  output logic             more
);

  localparam int WCNT_W = $clog2(SHORT_WAITS + 1);
  localparam logic [WCNT_W-1:0] WLIM = WCNT_W'(SHORT_WAITS);

  logic [WCNT_W-1:0] wcnt_q;
  logic              waiting;

  assign waiting = in_sync && !ack_i && !fault_i;
  assign err     = in_sync && lframe_n && fault_i;
  assign done    = in_sync && lframe_n && ack_i && !fault_i;
  assign more    = done && !final_byte;

  always_comb begin
    if (fault_i)    code = SYNC_ERR;
    else if (ack_i) code = done_code(final_byte);
    else            code = wait_code(32'(wcnt_q), SHORT_WAITS);
  end

  // counts wait clocks of the current window, saturating at the budget
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wcnt_q <= '0;
    else if (!in_sync)
      wcnt_q <= '0;
    else if (waiting && (wcnt_q < WLIM))
      wcnt_q <= wcnt_q + 1'b1;
  end

endmodule

// File: rtl/lpcdma_dpath.sv
module lpcdma_dpath
  import lpcdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dma_st_e           st,
  input  logic [NIB_W-1:0]  lad_i,
  input  logic [BYTE_W-1:0] rdata_i,
  input  logic              sync_done,
  input  logic [NIB_W-1:0]  sync_code,
  output logic [CHAN_W-1:0] chan,
  output logic              tc,
  output logic              final_byte,
  output logic [BYTE_W-1:0] wbyte,
  output logic [NIB_W-1:0]  lad_o
);

  logic [CHAN_W-1:0] chan_q;
  logic              tc_q;
  logic [IDX_W-1:0]  lastidx_q;
  logic [IDX_W-1:0]  bidx_q;
  logic [BYTE_W-1:0] wbyte_q;
  logic [BYTE_W-1:0] rbyte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q    <= '0;
      tc_q      <= 1'b0;
      lastidx_q <= '0;
      bidx_q    <= '0;
      wbyte_q   <= '0;
      rbyte_q   <= '0;
    end else begin
      case (st)
        ST_CHAN: begin
          chan_q <= lad_i[CHAN_W-1:0];
          tc_q   <= lad_i[3];
        end
        ST_SIZE: begin
          lastidx_q <= size_last_idx(lad_i[1:0]);
          bidx_q    <= '0;
        end
        ST_DIN_HI: wbyte_q[7:4] <= lad_i;
        ST_DIN_LO: wbyte_q[3:0] <= lad_i;
        default: ;
      endcase
      if (sync_done) begin
        bidx_q  <= bidx_q + 1'b1;
        rbyte_q <= rdata_i;
      end
    end
  end

  assign final_byte = (bidx_q == lastidx_q) || tc_q;
  assign chan       = chan_q;
  assign tc         = tc_q;
  assign wbyte      = wbyte_q;

  always_comb begin
    case (st)
      ST_SYNC:    lad_o = sync_code;
      ST_DOUT_HI: lad_o = rbyte_q[7:4];
      ST_DOUT_LO: lad_o = rbyte_q[3:0];
      ST_PTAR1:   lad_o = NIB_ONES;
      default:    lad_o = '0;
    endcase
  end

endmodule

// File: rtl/lpcdma_periph.sv
module lpcdma_periph
  import lpcdma_pkg::*;
#(
  parameter int SHORT_WAITS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lframe_n,
  input  logic [3:0]  lad_i,
  output logic [3:0]  lad_o,
  output logic        lad_oe,
  output logic        req_o,
  output logic        dir_o,
  output logic [2:0]  chan_o,
  output logic        tc_o,
  output logic [7:0]  wdata_o,
  input  logic [7:0]  rdata_i,
  input  logic        ack_i,
  input  logic        fault_i
);

  dma_st_e          st;
  logic             in_sync;
  logic             sync_done;
  logic             sync_err;
  logic             sync_more;
  logic             final_byte;
  logic [NIB_W-1:0] sync_code;
  logic             st_ptar1;
  logic             ev_abort;

  assign in_sync  = (st == ST_SYNC);
  assign st_ptar1 = (st == ST_PTAR1);
  assign req_o    = in_sync;

  lpcdma_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lframe_n  (lframe_n),
    .lad_i     (lad_i),
    .sync_done (sync_done),
    .sync_err  (sync_err),
    .sync_more (sync_more),
    .st        (st),
    .dir       (dir_o),
    .lad_oe    (lad_oe),
    .ev_abort  (ev_abort)
  );

  lpcdma_sync #(.SHORT_WAITS(SHORT_WAITS)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_sync    (in_sync),
    .lframe_n   (lframe_n),
    .ack_i      (ack_i),
    .fault_i    (fault_i),
    .final_byte (final_byte),
    .code       (sync_code),
    .done       (sync_done),
    .err        (sync_err),
    .more       (sync_more)
  );

  lpcdma_dpath u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .lad_i      (lad_i),
    .rdata_i    (rdata_i),
    .sync_done  (sync_done),
    .sync_code  (sync_code),
    .chan       (chan_o),
    .tc         (tc_o),
    .final_byte (final_byte),
    .wbyte      (wdata_o),
    .lad_o      (lad_o)
  );

endmodule

// File: rtl/lpcdma_chk.sv
module lpcdma_chk #(
  parameter int SHORT_WAITS = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lframe_n,
  input logic [3:0] lad_o,
  input logic       lad_oe,
  input logic       req_o,
  input logic       ack_i,
  input logic       fault_i,
  input logic       tc_o,
  input logic [2:0] chan_o,
  input logic       st_ptar1,
  input logic       ev_abort
);

  localparam int RUN_W = $clog2(SHORT_WAITS + 2) + 1;
  logic [RUN_W-1:0] run5_q;
  logic             short_now;

  assign short_now = lad_oe && (lad_o == 4'h5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run5_q <= '0;
    else if (!short_now)       run5_q <= '0;
    else if (run5_q != '1)     run5_q <= run5_q + 1'b1;
  end

  a_r7_short_bound: assert property (@(posedge clk) disable iff (!rst_n)
    short_now |-> (32'(run5_q) < SHORT_WAITS));

  a_r12_req_drives: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> lad_oe);

  a_r9_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && fault_i && lframe_n) |-> (lad_o == 4'hA));

  a_r9_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && fault_i && lframe_n) |=> st_ptar1);

  a_r8_tc_no_more: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && tc_o && lframe_n) |-> (lad_o != 4'h9));

  a_r8_more_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && (lad_o == 4'h9)) |-> ack_i);

  a_r6_tar_ones: assert property (@(posedge clk) disable iff (!rst_n)
    st_ptar1 |-> (lad_oe && (lad_o == 4'hF)));

  a_r6_tar_release: assert property (@(posedge clk) disable iff (!rst_n)
    st_ptar1 |=> !lad_oe);

  a_r11_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !lad_oe);

  a_r3_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && $past(req_o)) |-> ($stable(chan_o) && $stable(tc_o)));

endmodule

bind lpcdma_periph lpcdma_chk #(.SHORT_WAITS(SHORT_WAITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lframe_n (lframe_n),
  .lad_o    (lad_o),
  .lad_oe   (lad_oe),
  .req_o    (req_o),
  .ack_i    (ack_i),
  .fault_i  (fault_i),
  .tc_o     (tc_o),
  .chan_o   (chan_o),
  .st_ptar1 (st_ptar1),
  .ev_abort (ev_abort)
);

// File: tb/tb_lpcdma_periph.sv
`timescale 1ns/1ps
module tb_lpcdma_periph;

  localparam int SW = 7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lframe_n;
  logic [3:0] lad_i;
  logic [3:0] lad_o;
  logic       lad_oe;
  logic       req_o;
  logic       dir_o;
  logic [2:0] chan_o;
  logic       tc_o;
  logic [7:0] wdata_o;
  logic [7:0] rdata_i;
  logic       ack_i;
  logic       fault_i;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lpcdma_periph #(.SHORT_WAITS(SW)) dut (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_i(lad_i),
    .lad_o(lad_o), .lad_oe(lad_oe), .req_o(req_o), .dir_o(dir_o),
    .chan_o(chan_o), .tc_o(tc_o), .wdata_o(wdata_o), .rdata_i(rdata_i),
    .ack_i(ack_i), .fault_i(fault_i)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one bus clock's inputs just after a falling edge, settle 1 ns
  task automatic drive(input logic fr, input logic [3:0] nib,
                       input logic ak, input logic ft, input logic [7:0] rd);
    lframe_n = fr; lad_i = nib; ack_i = ak; fault_i = ft; rdata_i = rd;
    #1;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic idle_check(input string req);
    check({req, " oe"}, lad_oe, 0);
    check({req, " req"}, req_o, 0);
  endtask

  function automatic logic [7:0] pat(input int run, input int b, input int salt);
    return 8'((run * 37 + b * 91 + salt) & 8'hFF);
  endfunction

  // waits in the SYNC window, then the acknowledge clock; returns the code
  task automatic sync_phase(input int waits, input logic ft, input logic [7:0] rd,
                            input logic [3:0] exp_code, input logic dir,
                            input logic [7:0] wexp);
    for (int w = 0; w < waits; w++) begin
      drive(1, 4'hF, 0, 0, 8'h00);
      check("R12 req in sync", req_o, 1);
      check("R12 oe in sync", lad_oe, 1);
      check("R7 wait code", lad_o, (w < SW) ? 5 : 6);
      nxt();
    end
    drive(1, 4'hF, 1, ft, rd);
    check("R12 req at ack", req_o, 1);
    check(ft ? "R9 error code" : "R8 completion code", lad_o, exp_code);
    check("R2 direction", dir_o, dir);
    if (!dir) check("R5 received byte", wdata_o, wexp);
    nxt();
  endtask

  task automatic own_tar();
    drive(1, 4'hF, 0, 0, 8'h00);
    check("R6 tar drive", lad_oe, 1);
    check("R6 tar ones", lad_o, 4'hF);
    nxt();
    drive(1, 4'hF, 0, 0, 8'h00);
    check("R6 tar release", lad_oe, 0);
    nxt();
  endtask

  // full DMA cycle; fsel 0 none, 1 fault alone on byte 0, 2 fault with ack on final byte
  task automatic run_cycle(input int run, input logic dir, input logic [2:0] ch,
                           input logic tc, input logic [1:0] sz, input int fsel,
                           input logic skip_start);
    int nb, eff;
    logic [3:0] code;
    logic ft;
    nb  = (sz == 2'b11) ? 4 : int'(sz) + 1;
    eff = tc ? 1 : nb;
    if (!skip_start) begin
      drive(0, 4'h0, 0, 0, 8'h00);
      check("R2 quiet at start", lad_oe, 0);
      nxt();
    end
    drive(1, {2'b10, dir, 1'b0}, 0, 0, 8'h00); nxt();
    drive(1, {tc, ch}, 0, 0, 8'h00); nxt();
    drive(1, {2'b00, sz}, 0, 0, 8'h00);
    check("R3 channel", chan_o, ch);
    check("R3 terminal count", tc_o, tc);
    check("R4 quiet in size", lad_oe, 0);
    nxt();
    if (dir) begin
      for (int t = 0; t < 2; t++) begin
        drive(1, 4'hF, 0, 0, 8'h00);
        check("R6 host tar quiet", lad_oe, 0);
        nxt();
      end
    end
    for (int b = 0; b < eff; b++) begin
      logic [7:0] by;
      int waits;
      by = pat(run, b, dir ? 5 : 11);
      waits = (run * 3 + b * 4) % 12;
      ft = (fsel == 1 && b == 0) || (fsel == 2 && b == eff - 1);
      code = ft ? 4'hA : ((b == eff - 1) ? 4'h0 : 4'h9);
      if (!dir) begin
        drive(1, by[7:4], 0, 0, 8'h00);
        check("R5 quiet in data", lad_oe, 0); nxt();
        drive(1, by[3:0], 0, 0, 8'h00); nxt();
        for (int t = 0; t < 2; t++) begin
          drive(1, 4'hF, 0, 0, 8'h00);
          check("R6 host tar quiet", lad_oe, 0);
          nxt();
        end
        if (fsel == 1 && b == 0) begin
          for (int w = 0; w < waits; w++) begin
            drive(1, 4'hF, 0, 0, 8'h00);
            check("R7 wait code", lad_o, (w < SW) ? 5 : 6); nxt();
          end
          drive(1, 4'hF, 0, 1, 8'h00);
          check("R9 error without ack", lad_o, 4'hA);
          nxt();
        end else begin
          sync_phase(waits, ft, 8'h00, code, dir, by);
        end
        own_tar();
      end else begin
        sync_phase(waits, ft, by, code, dir, 8'h00);
        if (!ft) begin
          drive(1, 4'hF, 0, 0, 8'h00);
          check("R10 high nibble oe", lad_oe, 1);
          check("R10 high nibble", lad_o, by[7:4]); nxt();
          drive(1, 4'hF, 0, 0, 8'h00);
          check("R10 low nibble", lad_o, by[3:0]); nxt();
        end
        if (code != 4'h9) own_tar();
      end
      if (code != 4'h9) break;
    end
    drive(1, 4'hF, 0, 0, 8'h00);
    idle_check("R8 idle after cycle");
    nxt();
  endtask

  task automatic reject(input logic [3:0] ct, input logic [3:0] szn, input string req);
    drive(0, 4'h0, 0, 0, 8'h00); nxt();
    drive(1, ct, 0, 0, 8'h00); nxt();
    drive(1, 4'h2, 0, 0, 8'h00); nxt();
    drive(1, szn, 0, 0, 8'h00); nxt();
    for (int k = 0; k < 8; k++) begin
      drive(1, 4'(k * 3 + 1), 1, 0, 8'h00);
      idle_check(req);
      nxt();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion earlier", 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    int run;
    rst_n = 0;
    drive(1, 4'hF, 0, 0, 8'h00);
    repeat (3) nxt();
    check("R1 reset oe", lad_oe, 0);
    check("R1 reset req", req_o, 0);
    rst_n = 1;
    nxt();
    idle_check("R1 after reset");

    // sweep direction, size, terminal count and fault placement
    run = 0;
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 4; s++) begin
        if (s == 2) continue;
        for (int t = 0; t < 2; t++)
          for (int f = 0; f < 3; f++) begin
            run_cycle(run, d[0], 3'(run % 8), t[0], s[1:0], f, 0);
            run++;
          end
      end

    // R2 ignored cycle types, R4 rejected sizes
    reject(4'h0, 4'h0, "R2 io type ignored");
    reject(4'h2, 4'h0, "R2 io write ignored");
    reject(4'h6, 4'h1, "R2 mem type ignored");
    reject(4'hC, 4'h0, "R2 reserved type ignored");
    reject(4'hE, 4'h3, "R2 reserved type ignored");
    reject(4'h8, 4'h2, "R4 size 10 rejected");
    reject(4'hA, 4'h4, "R4 size upper bits rejected");
    reject(4'h8, 4'h9, "R4 size upper bits rejected");

    // R11 abort inside a wait window (device-to-host)
    drive(0, 4'h0, 0, 0, 8'h00); nxt();
    drive(1, 4'hA, 0, 0, 8'h00); nxt();
    drive(1, 4'h5, 0, 0, 8'h00); nxt();
    drive(1, 4'h1, 0, 0, 8'h00); nxt();
    drive(1, 4'hF, 0, 0, 8'h00); nxt();
    drive(1, 4'hF, 0, 0, 8'h00); nxt();
    drive(1, 4'hF, 0, 0, 8'h00);
    check("R11 in sync before abort", req_o, 1); nxt();
    drive(0, 4'hF, 0, 0, 8'h00); nxt();
    drive(1, 4'hF, 0, 0, 8'h00);
    idle_check("R11 abort in sync");
    nxt();

    // R11 abort with start nibble during a data nibble, new cycle follows
    drive(0, 4'h0, 0, 0, 8'h00); nxt();
    drive(1, 4'h8, 0, 0, 8'h00); nxt();
    drive(1, 4'h3, 0, 0, 8'h00); nxt();
    drive(1, 4'h0, 0, 0, 8'h00); nxt();
    drive(1, 4'h7, 0, 0, 8'h00); nxt();
    drive(0, 4'h0, 0, 0, 8'h00);
    check("R11 quiet at restart", lad_oe, 0); nxt();
    run_cycle(200, 1'b1, 3'd6, 1'b0, 2'b01, 0, 1);

    // R11 abort on the block's own turn-around clock
    drive(0, 4'h0, 0, 0, 8'h00); nxt();
    drive(1, 4'h8, 0, 0, 8'h00); nxt();
    drive(1, 4'h1, 0, 0, 8'h00); nxt();
    drive(1, 4'h0, 0, 0, 8'h00); nxt();
    drive(1, 4'hC, 0, 0, 8'h00); nxt();
    drive(1, 4'h3, 0, 0, 8'h00); nxt();
    drive(1, 4'hF, 0, 0, 8'h00); nxt();
    drive(1, 4'hF, 0, 0, 8'h00); nxt();
    drive(1, 4'hF, 1, 0, 8'h00);
    check("R8 single byte ready", lad_o, 4'h0); nxt();
    drive(0, 4'hF, 0, 0, 8'h00); nxt();
    drive(1, 4'hF, 0, 0, 8'h00);
    idle_check("R11 abort in tar");
    nxt();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

endmodule